// File: doc/BRIEF.md
# Windowed Register File with Working-Window Copy

This block is the integer register file of a multi-threaded core that uses overlapping register windows. Every thread owns a ring of register windows. Each window shows the instruction 24 registers, split into three groups of eight: outputs, locals and inputs. The output group of one window is the same physical storage as the input group of the window after it. A procedure call (SAVE) can therefore pass arguments without copying, and a return (RESTORE) brings them back.

Storage has two levels. A backing store holds every window of every thread. A 24-entry working copy holds only the active window of the active thread, and the three read ports are served from it. Two write ports update both levels in the same cycle. One port carries short-latency results and the other carries long-latency results.

A SAVE, a RESTORE or a change of the thread-id input starts a refill. The refill copies the 24 registers of the new window from the backing store into the working copy, one register per cycle. While it runs, `busy_o` is high. A controller state machine has two states:
- `ST_IDLE` leaves through `GO_REFILL` on an accepted window change or a thread switch.
- `ST_REFILL` leaves through `FILL_DONE` once the last of the 24 registers has been copied.

A SAVE past the depth limit does not move the pointer and raises an overflow pulse. A RESTORE below it does not move the pointer and raises an underflow pulse.

Top module: `windowed_regfile`

## Requirements
- R1: Window-relative address 0–7 selects the outputs, 8–15 the locals and 16–23 the inputs. The three read ports are combinational and independent. Reads at addresses 24–31 return zero, and writes to those addresses are dropped.
- R2: A write on either port is returned by any read port in the next cycle. The backing store and the working copy are updated on the same clock edge.
- R3: The output register k (k in 0–7) of window w and the input register 16+k of window w+1 are the same storage. Values written through either name are seen through the other after a SAVE or a RESTORE.
- R4: An accepted SAVE adds one to the active thread's window pointer and an accepted RESTORE subtracts one, both modulo NWIN. When SAVE and RESTORE are asserted together, SAVE is taken.
- R5: An accepted window change or a thread switch holds `busy_o` high for exactly 24 cycles, starting the cycle after the request. All three read ports return zero while `busy_o` is high.
- R6: Each thread keeps a depth count that starts at 0.
  - A SAVE at depth MAX_DEPTH is rejected: `ovf_o` is high for one cycle, the pointer does not move and no refill starts.
  - A RESTORE at depth 0 is rejected in the same way, with `unf_o` as the flag.
- R7: When both write ports target the same address in one cycle, the long-latency port's data is stored.
- R8: Each of the NTHREADS threads has its own storage, window pointer and depth. A change of `tid_i` while idle switches the active thread and refills the working copy.
- R9: While `busy_o` is high, SAVE and RESTORE are ignored and a thread change waits until the refill ends. Writes made during a refill are kept.
- R10: After reset every register reads zero, each pointer equals CWP_INIT, each depth is 0, thread 0 is active and `busy_o`, `ovf_o` and `unf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tid_i | input | TW | Selected thread |
| save_i | input | 1 | Window advance request |
| restore_i | input | 1 | Window retreat request |
| ws_en_i | input | 1 | Short-latency write enable |
| ws_addr_i | input | 5 | Short-latency write address (window-relative) |
| ws_data_i | input | DW | Short-latency write data |
| wl_en_i | input | 1 | Long-latency write enable |
| wl_addr_i | input | 5 | Long-latency write address |
| wl_data_i | input | DW | Long-latency write data |
| ra_addr_i | input | 5 | Read port A address |
| rb_addr_i | input | 5 | Read port B address |
| rc_addr_i | input | 5 | Read port C address |
| ra_data_o | output | DW | Read port A data |
| rb_data_o | output | DW | Read port B data |
| rc_data_o | output | DW | Read port C data |
| busy_o | output | 1 | Refill in progress |
| ovf_o | output | 1 | SAVE rejected at the depth limit |
| unf_o | output | 1 | RESTORE rejected at depth 0 |

## Verification
The bench builds the block with four threads, eight windows, 16-bit data, MAX_DEPTH = 3 and CWP_INIT = 6. Starting the pointer at window 6 makes the second SAVE wrap from window 7 to window 0, so the modulo arithmetic and the alias across the wrap get checked. The small depth limit reaches overflow after three SAVEs and underflow right after returning. The bench also switches threads mid-run to show that storage and pointers are kept per thread.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REFILL = 1'b1
    } wrf_state_e;

    localparam int GRP_REGS  = 8;
    localparam int WIN_REGS  = 3 * GRP_REGS;
    localparam int SLOT_REGS = 2 * GRP_REGS;
    localparam int AW        = 5;
    localparam int FW        = $clog2(WIN_REGS);
endpackage

// File: rtl/wrf_ctl.sv
module wrf_ctl
    import wrf_pkg::*;
#(
    parameter int NTHREADS  = 4,
    parameter int NWIN      = 8,
    parameter int MAX_DEPTH = 6,
    parameter int CWP_INIT  = 0,
    localparam int TW  = $clog2(NTHREADS),
    localparam int WW  = $clog2(NWIN),
    localparam int DPW = $clog2(NWIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tid_i,
    input  logic          save_i,
    input  logic          restore_i,
    output logic [TW-1:0] act_tid_o,
    output logic [WW-1:0] cwp_o,
    output logic [FW-1:0] fill_idx_o,
    output logic          fill_en_o,
    output logic          busy_o,
    output logic          ovf_o,
    output logic          unf_o
);
    localparam logic [FW-1:0]  FILL_LAST = FW'(WIN_REGS - 1);
    localparam logic [DPW-1:0] DEPTH_TOP = DPW'(MAX_DEPTH);

    wrf_state_e     state_q, state_d;
    logic [FW-1:0]  cnt_q;
    logic [TW-1:0]  act_q;
    logic [WW-1:0]  cwp_q   [NTHREADS];
    logic [DPW-1:0] depth_q [NTHREADS];
    logic           ovf_q, unf_q;

    logic sw_tid, idle, at_top, at_bottom;
    logic take_save, rej_save, take_rest, rej_rest;

    always_comb begin
        idle      = (state_q == ST_IDLE);
        sw_tid    = (tid_i != act_q);
        at_top    = (depth_q[act_q] == DEPTH_TOP);
        at_bottom = (depth_q[act_q] == '0);
        take_save = idle && !sw_tid && save_i && !at_top;
        rej_save  = idle && !sw_tid && save_i && at_top;
        take_rest = idle && !sw_tid && !save_i && restore_i && !at_bottom;
        rej_rest  = idle && !sw_tid && !save_i && restore_i && at_bottom;
    end

    // next state: GO_REFILL from ST_IDLE, FILL_DONE from ST_REFILL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sw_tid || take_save || take_rest) state_d = ST_REFILL;
            ST_REFILL: if (cnt_q == FILL_LAST)               state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            for (int t = 0; t < NTHREADS; t++) begin
                cwp_q[t]   <= WW'(CWP_INIT);
                depth_q[t] <= '0;
            end
        end else begin
            ovf_q <= rej_save;
            unf_q <= rej_rest;
            if (idle) begin
                cnt_q <= '0;
                if (sw_tid) act_q <= tid_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (take_save) begin
                cwp_q[act_q]   <= cwp_q[act_q] + 1'b1;
                depth_q[act_q] <= depth_q[act_q] + 1'b1;
            end else if (take_rest) begin
                cwp_q[act_q]   <= cwp_q[act_q] - 1'b1;
                depth_q[act_q] <= depth_q[act_q] - 1'b1;
            end
        end
    end

    always_comb begin
        busy_o     = (state_q == ST_REFILL);
        fill_en_o  = (state_q == ST_REFILL);
        fill_idx_o = cnt_q;
        act_tid_o  = act_q;
        cwp_o      = cwp_q[act_q];
        ovf_o      = ovf_q;
        unf_o      = unf_q;
    end
endmodule

// File: rtl/wrf_backing.sv
module wrf_backing #(
    parameter int BW = 9,
    parameter int DW = 32,
    localparam int NENT = 1 << BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wa_en,
    input  logic [BW-1:0] wa_idx,
    input  logic [DW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [BW-1:0] wb_idx,
    input  logic [DW-1:0] wb_data,
    input  logic [BW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem_q [NENT];

    // port B (long latency) is applied last so it wins a collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) mem_q[i] <= '0;
        end else begin
            if (wa_en) mem_q[wa_idx] <= wa_data;
            if (wb_en) mem_q[wb_idx] <= wb_data;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/wrf_working.sv
module wrf_working
    import wrf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_en,
    input  logic [FW-1:0] fill_idx,
    input  logic [DW-1:0] fill_data,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [DW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    input  logic [AW-1:0] rc_addr,
    output logic [DW-1:0] ra_data,
    output logic [DW-1:0] rb_data,
    output logic [DW-1:0] rc_data
);
    logic [DW-1:0] win_q [WIN_REGS];

    // refill first, then port A, then port B: the latest value wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_REGS; i++) win_q[i] <= '0;
        end else begin
            if (fill_en) win_q[fill_idx] <= fill_data;
            if (wa_en)   win_q[wa_addr]  <= wa_data;
            if (wb_en)   win_q[wb_addr]  <= wb_data;
        end
    end

    function automatic logic [DW-1:0] pick(input logic [AW-1:0] a);
        return (a < AW'(WIN_REGS)) ? win_q[a] : '0;
    endfunction

    assign ra_data = pick(ra_addr);
    assign rb_data = pick(rb_addr);
    assign rc_data = pick(rc_addr);
endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile
    import wrf_pkg::*;
#(
    parameter int NTHREADS  = 4,
    parameter int NWIN      = 8,
    parameter int DW        = 32,
    parameter int MAX_DEPTH = NWIN - 2,
    parameter int CWP_INIT  = 0,
    localparam int TW = $clog2(NTHREADS),
    localparam int WW = $clog2(NWIN),
    localparam int BW = TW + WW + $clog2(SLOT_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tid_i,
    input  logic          save_i,
    input  logic          restore_i,
    input  logic          ws_en_i,
    input  logic [4:0]    ws_addr_i,
    input  logic [DW-1:0] ws_data_i,
    input  logic          wl_en_i,
    input  logic [4:0]    wl_addr_i,
    input  logic [DW-1:0] wl_data_i,
    input  logic [4:0]    ra_addr_i,
    input  logic [4:0]    rb_addr_i,
    input  logic [4:0]    rc_addr_i,
    output logic [DW-1:0] ra_data_o,
    output logic [DW-1:0] rb_data_o,
    output logic [DW-1:0] rc_data_o,
    output logic          busy_o,
    output logic          ovf_o,
    output logic          unf_o
);
    logic [TW-1:0] act_tid;
    logic [WW-1:0] cwp;
    logic [FW-1:0] fill_idx;
    logic          fill_en;
    logic [DW-1:0] fill_data;
    logic [DW-1:0] raw_a, raw_b, raw_c;
    logic          ws_ok, wl_ok;

    // outputs live in the next window's input slot; locals use the lower half
    function automatic logic [BW-1:0] phys_idx(input logic [TW-1:0] t,
                                               input logic [WW-1:0] w,
                                               input logic [4:0]    a);
        logic [WW-1:0] win;
        logic          hi;
        win = (a < 5'd8) ? w + 1'b1 : w;
        hi  = (a < 5'd8) || (a >= 5'd16);
        return {t, win, hi, a[2:0]};
    endfunction

    assign ws_ok = ws_en_i && (ws_addr_i < 5'(WIN_REGS));
    assign wl_ok = wl_en_i && (wl_addr_i < 5'(WIN_REGS));

    wrf_ctl #(
        .NTHREADS (NTHREADS),
        .NWIN     (NWIN),
        .MAX_DEPTH(MAX_DEPTH),
        .CWP_INIT (CWP_INIT)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tid_i     (tid_i),
        .save_i    (save_i),
        .restore_i (restore_i),
        .act_tid_o (act_tid),
        .cwp_o     (cwp),
        .fill_idx_o(fill_idx),
        .fill_en_o (fill_en),
        .busy_o    (busy_o),
        .ovf_o     (ovf_o),
        .unf_o     (unf_o)
    );

    wrf_backing #(.BW(BW), .DW(DW)) u_backing (
        .clk    (clk),
        .rst_n  (rst_n),
        .wa_en  (ws_ok),
        .wa_idx (phys_idx(act_tid, cwp, ws_addr_i)),
        .wa_data(ws_data_i),
        .wb_en  (wl_ok),
        .wb_idx (phys_idx(act_tid, cwp, wl_addr_i)),
        .wb_data(wl_data_i),
        .rd_idx (phys_idx(act_tid, cwp, 5'(fill_idx))),
        .rd_data(fill_data)
    );

    wrf_working #(.DW(DW)) u_working (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_en),
        .fill_idx (fill_idx),
        .fill_data(fill_data),
        .wa_en    (ws_ok),
        .wa_addr  (ws_addr_i),
        .wa_data  (ws_data_i),
        .wb_en    (wl_ok),
        .wb_addr  (wl_addr_i),
        .wb_data  (wl_data_i),
        .ra_addr  (ra_addr_i),
        .rb_addr  (rb_addr_i),
        .rc_addr  (rc_addr_i),
        .ra_data  (raw_a),
        .rb_data  (raw_b),
        .rc_data  (raw_c)
    );

    assign ra_data_o = busy_o ? '0 : raw_a;
    assign rb_data_o = busy_o ? '0 : raw_b;
    assign rc_data_o = busy_o ? '0 : raw_c;
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
    parameter int TW = 2,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          save_i,
    input logic          restore_i,
    input logic [TW-1:0] tid_i,
    input logic [TW-1:0] act_tid,
    input logic          wl_en_i,
    input logic [4:0]    wl_addr_i,
    input logic [DW-1:0] wl_data_i,
    input logic [4:0]    ra_addr_i,
    input logic [DW-1:0] ra_data_o,
    input logic          busy_o,
    input logic          ovf_o,
    input logic          unf_o
);
    logic [5:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (busy_o) run_q <= run_q + 6'd1;
        else             run_q <= '0;
    end

    assert_refill_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_q == 6'd24));

    assert_refill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 6'd24);

    assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(save_i) || $past(restore_i) || ($past(tid_i) != $past(act_tid))));

    assert_thread_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(act_tid));

    assert_flag_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o || unf_o) |-> (!busy_o && !(ovf_o && unf_o)));

    assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(save_i));

    assert_unf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> $past(restore_i));

    assert_long_write_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wl_en_i) && ($past(wl_addr_i) < 5'd24) && !busy_o && (ra_addr_i == $past(wl_addr_i)))
            |-> (ra_data_o == $past(wl_data_i)));
endmodule

bind windowed_regfile wrf_checker #(.TW(TW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .save_i   (save_i),
    .restore_i(restore_i),
    .tid_i    (tid_i),
    .act_tid  (act_tid),
    .wl_en_i  (wl_en_i),
    .wl_addr_i(wl_addr_i),
    .wl_data_i(wl_data_i),
    .ra_addr_i(ra_addr_i),
    .ra_data_o(ra_data_o),
    .busy_o   (busy_o),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o)
);

// File: tb/tb_windowed_regfile.sv
`timescale 1ns/1ps
module tb_windowed_regfile;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    tid_i = '0;
    logic          save_i = 1'b0, restore_i = 1'b0;
    logic          ws_en_i = 1'b0, wl_en_i = 1'b0;
    logic [4:0]    ws_addr_i = '0, wl_addr_i = '0;
    logic [DW-1:0] ws_data_i = '0, wl_data_i = '0;
    logic [4:0]    ra_addr_i = '0, rb_addr_i = '0, rc_addr_i = '0;
    logic [DW-1:0] ra_data_o, rb_data_o, rc_data_o;
    logic          busy_o, ovf_o, unf_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    windowed_regfile #(
        .NTHREADS(4), .NWIN(8), .DW(DW), .MAX_DEPTH(3), .CWP_INIT(6)
    ) dut (.*);

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_s(input logic [4:0] a, input logic [DW-1:0] d);
        ws_en_i = 1'b1; ws_addr_i = a; ws_data_i = d;
        tick();
        ws_en_i = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [DW-1:0] exp);
        ra_addr_i = a;
        #0.1;
        chk(req, ra_data_o, exp);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o && n < 100) begin
            n++;
            tick();
        end
    endtask

    task automatic win_op(input bit is_save, input string req);
        int n;
        save_i = is_save; restore_i = !is_save;
        tick();
        save_i = 1'b0; restore_i = 1'b0;
        ra_addr_i = 5'd9;
        #0.1;
        chk({req, " read zero while busy"}, ra_data_o, '0);
        wait_idle(n);
        chk({req, " busy length"}, DW'(n), DW'(24));
    endtask

    task automatic t_reset();
        chk("R10 busy", DW'(busy_o), '0);
        chk("R10 ovf/unf", DW'({ovf_o, unf_o}), '0);
        rd("R10 local zero", 5'd9, '0);
        rd("R10 in zero", 5'd16, '0);
    endtask

    task automatic t_rw();
        wr_s(5'd9, 16'h1009);
        ra_addr_i = 5'd9; rb_addr_i = 5'd9; rc_addr_i = 5'd9;
        #0.1;
        chk("R2 port A", ra_data_o, 16'h1009);
        chk("R1 port B", rb_data_o, 16'h1009);
        chk("R1 port C", rc_data_o, 16'h1009);
        wr_s(5'd26, 16'hDEAD);
        rd("R1 high address reads zero", 5'd26, '0);
    endtask

    task automatic t_collide();
        ws_en_i = 1'b1; ws_addr_i = 5'd11; ws_data_i = 16'hAAAA;
        wl_en_i = 1'b1; wl_addr_i = 5'd11; wl_data_i = 16'hBBBB;
        tick();
        ws_en_i = 1'b0; wl_en_i = 1'b0;
        rd("R7 long port wins", 5'd11, 16'hBBBB);
    endtask

    task automatic t_alias();
        wr_s(5'd2, 16'h0602);
        win_op(1'b1, "R5 save");
        rd("R3 out becomes in", 5'd18, 16'h0602);
        rd("R1 new window locals", 5'd9, '0);
    endtask

    task automatic t_wrap();
        wr_s(5'd3, 16'h0703);
        win_op(1'b1, "R4 save wrap");
        rd("R4 wrap 7 to 0 alias", 5'd19, 16'h0703);
        wr_s(5'd9, 16'h0009);
    endtask

    task automatic t_overflow();
        win_op(1'b1, "R4 save");
        save_i = 1'b1;
        tick();
        save_i = 1'b0;
        chk("R6 ovf pulse", DW'(ovf_o), DW'(1));
        chk("R6 ovf no refill", DW'(busy_o), '0);
        tick();
        chk("R6 ovf one cycle", DW'(ovf_o), '0);
    endtask

    task automatic t_restore();
        win_op(1'b0, "R4 restore");
        rd("R4 back in window 0", 5'd9, 16'h0009);
        win_op(1'b0, "R4 restore");
        win_op(1'b0, "R4 restore");
        rd("R3 local kept window 6", 5'd9, 16'h1009);
        rd("R3 out kept window 6", 5'd2, 16'h0602);
        rd("R7 collided value kept", 5'd11, 16'hBBBB);
    endtask

    task automatic t_underflow();
        restore_i = 1'b1;
        tick();
        restore_i = 1'b0;
        chk("R6 unf pulse", DW'(unf_o), DW'(1));
        chk("R6 unf no refill", DW'(busy_o), '0);
        rd("R6 window unchanged", 5'd9, 16'h1009);
    endtask

    task automatic t_busy_ignore();
        int n;
        wr_s(5'd5, 16'h0605);
        save_i = 1'b1;
        tick();
        save_i = 1'b1;
        ws_en_i = 1'b1; ws_addr_i = 5'd10; ws_data_i = 16'h7777;
        tick();
        save_i = 1'b0; ws_en_i = 1'b0;
        wait_idle(n);
        chk("R9 refill length unchanged", DW'(n + 1), DW'(24));
        rd("R9 second save ignored", 5'd21, 16'h0605);
        rd("R9 write during refill kept", 5'd10, 16'h7777);
        win_op(1'b0, "R9 restore");
        rd("R9 back to window 6", 5'd9, 16'h1009);
    endtask

    task automatic t_thread();
        int n;
        tid_i = 2'd1;
        tick();
        wait_idle(n);
        chk("R8 switch refill length", DW'(n), DW'(24));
        rd("R8 thread 1 separate", 5'd9, '0);
        wr_s(5'd9, 16'h1111);
        win_op(1'b1, "R8 thread 1 save");
        tid_i = 2'd0;
        tick();
        wait_idle(n);
        rd("R8 thread 0 restored", 5'd9, 16'h1009);
        restore_i = 1'b1;
        tick();
        restore_i = 1'b0;
        chk("R8 thread 0 depth own", DW'(unf_o), DW'(1));
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_rw();
        t_collide();
        t_alias();
        t_wrap();
        t_overflow();
        t_restore();
        t_underflow();
        t_busy_ignore();
        t_thread();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule